// File: doc/BRIEF.md
# Tap Event Duration Qualifier

This block decides whether short bursts in a stream of jerk magnitude samples are taps. A burst counts only while each judged sample lies strictly inside a band set by a low and a high threshold. The block measures how long a burst stays in that band, in timing ticks, and accepts it only when that length lies between a programmable minimum and maximum. An accepted burst is held as a pending first tap for a fixed window. If a second burst starts inside that window, the pair is judged as a double tap: the second burst must pass the same length test, and the in-band time of both bursts added together must not exceed a total limit. If no second burst starts, a single-tap pulse follows when the window closes.

One timing tick spans one, two or four sample strobes, chosen by a rate code. Only the sample that arrives with a tick is judged. The tick therefore keeps the same length in time at 400 Hz, 800 Hz and 1600 Hz sample rates.

The four configuration registers are written through a simple write port. A write lands only while the operate input is low. Lowering the operate input also clears all detection state.

Top module: `tap_qualifier`

## Requirements
- R1: A judged sample is in band only when it is strictly greater than the low threshold and strictly less than the high threshold. After reset the low threshold is 26 and the high threshold is 200.
- R2: A tick occurs on every sample strobe for rate code 0, on every second strobe for code 1, and on every fourth strobe for codes 2 and 3. Only the sample that comes with a tick is judged.
- R3: The timing register (address 2) holds the maximum length in bits [7:3] and the minimum length in bits [2:0], and resets to 0xA2. A burst is valid when its count of in-band ticks is at least the minimum and at most the maximum.
- R4: A valid first burst with no second burst produces a single-tap pulse on the 64th out-of-band tick after the tick that ended the burst. If a second burst starts on any of those 64 ticks, it is judged as the second tap of a pair.
- R5: When the second burst is valid, a double-tap pulse is issued if the summed in-band ticks of both bursts are no greater than the total register (address 3, reset 0x24). If the sum is greater, no pulse is issued.
- R6: When the second burst has an invalid length, a single-tap pulse for the first tap is issued on the tick that ends the second burst.
- R7: A write goes to the register selected by the address: 0 high threshold, 1 low threshold, 2 timing, 3 total. It lands only while the operate input is 0. Writes made while the operate input is 1 are ignored.
- R8: While the operate input is 0, the pending tap, the burst counters and the tick prescaler are cleared, and no pulse is issued.
- R9: Each pulse lasts one clock and appears on the clock after the edge that sampled the deciding tick. The two pulses never occur together.
- R10: The length and sum counters saturate instead of wrapping, so a burst far longer than the maximum is still rejected.
- R11: A synchronous active-high reset loads every register reset value, clears all state and holds both pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oper | input | 1 | Operate enable; 0 allows writes and clears detection |
| rate_sel | input | 2 | Rate code for tick scaling |
| smp_valid | input | 1 | Sample strobe |
| smp_jerk | input | 8 | Jerk magnitude sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| single_tap | output | 1 | One-clock single-tap pulse |
| double_tap | output | 1 | One-clock double-tap pulse |

## Verification
The bench drives samples exactly equal to each threshold; a design that used inclusive comparisons would report taps there. It drives bursts at the minimum and maximum lengths and one tick beyond each, and a 70-tick burst against a maximum of 31, which a design with wrapping counters would wrongly accept. It starts second bursts on the last tick of the window and on the first tick after it, and uses pairs whose summed length sits exactly at the total limit and one tick above it; an off-by-one in either place turns a double into two singles or the reverse. It also issues register writes while operating, drops the operate input while a tap is pending, and repeats one burst length at each rate code. A design that let a write through, kept state it should have cleared, or scaled the tick wrongly would emit pulses where the reference model expects none.

// File: rtl/tapq_pkg.sv
package tapq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_HOLD   = 2'd2,
      ST_SECOND = 2'd3
   } tap_st_e;

   localparam logic [1:0] RATE_LOW  = 2'd0;
   localparam logic [1:0] RATE_MID  = 2'd1;
   localparam logic [1:0] RATE_HIGH = 2'd2;

   localparam logic [1:0] ADDR_THI  = 2'd0;
   localparam logic [1:0] ADDR_TLO  = 2'd1;
   localparam logic [1:0] ADDR_TIM  = 2'd2;
   localparam logic [1:0] ADDR_TOT  = 2'd3;

endpackage

// File: rtl/tapq_regs.sv
module tapq_regs
   import tapq_pkg::*;
#(
   parameter int DW      = 8,
   parameter int MAXW    = 5,
   parameter int MINW    = 3,
   parameter int TLW     = 8,
   parameter int HI_RST  = 200,
   parameter int LO_RST  = 26,
   parameter int TIM_RST = 8'hA2,
   parameter int TOT_RST = 8'h24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             oper,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    thr_hi,
   output logic [DW-1:0]    thr_lo,
   output logic [MAXW-1:0]  dur_max,
   output logic [MINW-1:0]  dur_min,
   output logic [TLW-1:0]   tot_lim
);

   localparam int TIMW = MAXW + MINW;

   if (TIMW > DW) begin : g_bad_tim
      $error("timing fields wider than write data");
   end
   if (TLW > DW) begin : g_bad_tot
      $error("total limit wider than write data");
   end

   logic [DW-1:0]   hi_q, lo_q;
   logic [TIMW-1:0] tim_q;
   logic [TLW-1:0]  tot_q;
   logic            wr_ok;

   assign wr_ok = wr_en && !oper;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q  <= DW'(HI_RST);
         lo_q  <= DW'(LO_RST);
         tim_q <= TIMW'(TIM_RST);
         tot_q <= TLW'(TOT_RST);
      end else if (wr_ok) begin
         case (wr_addr)
            ADDR_THI: hi_q  <= wr_data;
            ADDR_TLO: lo_q  <= wr_data;
            ADDR_TIM: tim_q <= wr_data[TIMW-1:0];
            default:  tot_q <= wr_data[TLW-1:0];
         endcase
      end
   end

   assign thr_hi  = hi_q;
   assign thr_lo  = lo_q;
   assign dur_max = tim_q[TIMW-1:MINW];
   assign dur_min = tim_q[MINW-1:0];
   assign tot_lim = tot_q;

   // R7
   locked_regs_chk: assert property (@(posedge clk) disable iff (rst)
      (oper && wr_en) |=> ($stable(thr_hi) && $stable(thr_lo) &&
                           $stable(dur_max) && $stable(dur_min) && $stable(tot_lim)));

endmodule

// File: rtl/tapq_tick.sv
module tapq_tick
   import tapq_pkg::*;
#(
   parameter int PRE_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       oper,
   input  logic       smp_valid,
   input  logic [1:0] rate_sel,
   output logic       tick
);

   if (PRE_LOG2 < 0 || PRE_LOG2 > 2) begin : g_bad_pre
      $error("prescaler range must be 0 to 2");
   end

   if (PRE_LOG2 == 0) begin : g_direct
      logic unused_rate;
      assign unused_rate = ^{rate_sel, clk, rst};
      assign tick = smp_valid && oper;
   end else begin : g_count
      localparam int PRE_W = PRE_LOG2;
      logic [PRE_W-1:0] pcnt_q;
      logic [PRE_W-1:0] div_m1;
      logic [1:0]       shft;

      always_comb begin
         if (rate_sel == RATE_LOW)      shft = 2'd0;
         else if (rate_sel == RATE_MID) shft = 2'd1;
         else                           shft = 2'd2;
         if (32'(shft) > PRE_LOG2)      shft = 2'(PRE_LOG2);
         div_m1 = PRE_W'((32'd1 << shft) - 32'd1);
      end

      assign tick = smp_valid && oper && (pcnt_q >= div_m1);

      always_ff @(posedge clk) begin
         if (rst || !oper) begin
            pcnt_q <= '0;
         end else if (smp_valid) begin
            if (pcnt_q >= div_m1) pcnt_q <= '0;
            else                  pcnt_q <= pcnt_q + 1'b1;
         end
      end

      // R2
      mid_rate_alt_chk: assert property (@(posedge clk) disable iff (rst)
         (tick && rate_sel == RATE_MID && $past(rate_sel) == RATE_MID && $past(oper))
         |-> !$past(tick));
   end

endmodule

// File: rtl/tapq_detect.sv
module tapq_detect
   import tapq_pkg::*;
#(
   parameter int DW   = 8,
   parameter int MAXW = 5,
   parameter int MINW = 3,
   parameter int TLW  = 8,
   parameter int WIN  = 64
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            oper,
   input  logic            tick,
   input  logic [DW-1:0]   sample,
   input  logic [DW-1:0]   thr_hi,
   input  logic [DW-1:0]   thr_lo,
   input  logic [MAXW-1:0] dur_max,
   input  logic [MINW-1:0] dur_min,
   input  logic [TLW-1:0]  tot_lim,
   output logic            single_tap,
   output logic            double_tap
);

   localparam int DUR_W = MAXW + 1;
   localparam int TOT_W = TLW + 1;
   localparam int GAP_W = $clog2(WIN);

   if (WIN < 2) begin : g_bad_win
      $error("window must span at least two ticks");
   end
   if (MINW > MAXW) begin : g_bad_min
      $error("minimum field wider than maximum field");
   end

   tap_st_e          st_q, st_n;
   logic [DUR_W-1:0] dur_q, dur_n, dur_inc;
   logic [TOT_W-1:0] tot_q, tot_n, tot_inc;
   logic [GAP_W-1:0] gap_q, gap_n;
   logic             sgl_q, sgl_n, dbl_q, dbl_n;
   logic             inb, dur_ok, tot_ok;

   assign inb     = (sample > thr_lo) && (sample < thr_hi);
   assign dur_inc = (&dur_q) ? dur_q : dur_q + 1'b1;
   assign tot_inc = (&tot_q) ? tot_q : tot_q + 1'b1;
   assign dur_ok  = (dur_q >= DUR_W'(dur_min)) && (dur_q <= DUR_W'(dur_max));
   assign tot_ok  = (tot_q <= TOT_W'(tot_lim));

   always_comb begin
      st_n  = st_q;
      dur_n = dur_q;
      tot_n = tot_q;
      gap_n = gap_q;
      sgl_n = 1'b0;
      dbl_n = 1'b0;
      if (tick) begin
         case (st_q)
            ST_IDLE: begin
               if (inb) begin
                  st_n  = ST_FIRST;
                  dur_n = DUR_W'(1);
                  tot_n = TOT_W'(1);
               end
            end
            ST_FIRST: begin
               if (inb) begin
                  dur_n = dur_inc;
                  tot_n = tot_inc;
               end else if (dur_ok) begin
                  st_n  = ST_HOLD;
                  gap_n = '0;
               end else begin
                  st_n  = ST_IDLE;
               end
            end
            ST_HOLD: begin
               if (inb) begin
                  st_n  = ST_SECOND;
                  dur_n = DUR_W'(1);
                  tot_n = tot_inc;
               end else if (gap_q == GAP_W'(WIN - 1)) begin
                  st_n  = ST_IDLE;
                  sgl_n = 1'b1;
               end else begin
                  gap_n = gap_q + 1'b1;
               end
            end
            default: begin
               if (inb) begin
                  dur_n = dur_inc;
                  tot_n = tot_inc;
               end else begin
                  st_n = ST_IDLE;
                  if (!dur_ok)     sgl_n = 1'b1;
                  else if (tot_ok) dbl_n = 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !oper) begin
         st_q  <= ST_IDLE;
         dur_q <= '0;
         tot_q <= '0;
         gap_q <= '0;
         sgl_q <= 1'b0;
         dbl_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         dur_q <= dur_n;
         tot_q <= tot_n;
         gap_q <= gap_n;
         sgl_q <= sgl_n;
         dbl_q <= dbl_n;
      end
   end

   assign single_tap = sgl_q;
   assign double_tap = dbl_q;

   // R9
   single_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
      single_tap |=> !single_tap);

   // R9
   double_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
      double_tap |=> !double_tap);

   // R9
   pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(single_tap && double_tap));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !oper |=> (!single_tap && !double_tap));

   // R5
   double_src_chk: assert property (@(posedge clk) disable iff (rst)
      double_tap |-> ($past(st_q) == ST_SECOND && $past(tick)));

endmodule

// File: rtl/tap_qualifier.sv
module tap_qualifier
   import tapq_pkg::*;
#(
   parameter int DW       = 8,
   parameter int MAXW     = 5,
   parameter int MINW     = 3,
   parameter int TLW      = 8,
   parameter int WIN      = 64,
   parameter int PRE_LOG2 = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          oper,
   input  logic [1:0]    rate_sel,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_jerk,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          single_tap,
   output logic          double_tap
);

   logic [DW-1:0]   thr_hi, thr_lo;
   logic [MAXW-1:0] dur_max;
   logic [MINW-1:0] dur_min;
   logic [TLW-1:0]  tot_lim;
   logic            tick;

   tapq_regs #(
      .DW(DW), .MAXW(MAXW), .MINW(MINW), .TLW(TLW)
   ) u_regs (
      .clk(clk), .rst(rst), .oper(oper),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .thr_hi(thr_hi), .thr_lo(thr_lo),
      .dur_max(dur_max), .dur_min(dur_min), .tot_lim(tot_lim)
   );

   tapq_tick #(
      .PRE_LOG2(PRE_LOG2)
   ) u_tick (
      .clk(clk), .rst(rst), .oper(oper),
      .smp_valid(smp_valid), .rate_sel(rate_sel), .tick(tick)
   );

   tapq_detect #(
      .DW(DW), .MAXW(MAXW), .MINW(MINW), .TLW(TLW), .WIN(WIN)
   ) u_detect (
      .clk(clk), .rst(rst), .oper(oper), .tick(tick), .sample(smp_jerk),
      .thr_hi(thr_hi), .thr_lo(thr_lo),
      .dur_max(dur_max), .dur_min(dur_min), .tot_lim(tot_lim),
      .single_tap(single_tap), .double_tap(double_tap)
   );

endmodule

// File: tb/test_tap_qualifier.sv
module test_tap_qualifier;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       oper = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       smp_valid = 1'b0;
   logic [7:0] smp_jerk = 8'd0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       single_tap, double_tap;

   int checks = 0, errors = 0, seen_s = 0, seen_d = 0, cyc = 0;
   string req = "R11";

   // reference model state
   int m_hi, m_lo, m_tim, m_tot, m_st, m_len, m_sum, m_gap, m_pc;
   bit m_s = 0, m_d = 0;

   tap_qualifier i_tap_qualifier (
      .clk(clk), .rst(rst), .oper(oper), .rate_sel(rate_sel),
      .smp_valid(smp_valid), .smp_jerk(smp_jerk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .single_tap(single_tap), .double_tap(double_tap)
   );

   always #10 clk = ~clk;

   task automatic judge(input int v);
      bit in_band;
      int mn, mx;
      in_band = (v > m_lo) && (v < m_hi);
      mn = m_tim % 8;
      mx = m_tim / 8;
      case (m_st)
         0: if (in_band) begin m_st = 1; m_len = 1; m_sum = 1; end
         1: if (in_band) begin m_len++; m_sum++; end
            else if (m_len >= mn && m_len <= mx) begin m_st = 2; m_gap = 0; end
            else m_st = 0;
         2: if (in_band) begin m_st = 3; m_len = 1; m_sum++; end
            else begin
               m_gap++;
               if (m_gap == 64) begin m_s = 1; m_st = 0; end
            end
         default: if (in_band) begin m_len++; m_sum++; end
            else begin
               m_st = 0;
               if (!(m_len >= mn && m_len <= mx)) m_s = 1;
               else if (m_sum <= m_tot) m_d = 1;
            end
      endcase
   endtask

   always @(posedge clk) begin
      int div;
      if (rst) begin
         m_hi = 200; m_lo = 26; m_tim = 'hA2; m_tot = 'h24;
         m_st = 0; m_pc = 0; m_s = 0; m_d = 0;
      end else begin
         m_s = 0; m_d = 0;
         if (!oper) begin
            m_st = 0; m_pc = 0;
            if (wr_en) begin
               case (wr_addr)
                  2'd0: m_hi = wr_data;
                  2'd1: m_lo = wr_data;
                  2'd2: m_tim = wr_data;
                  default: m_tot = wr_data;
               endcase
            end
         end else if (smp_valid) begin
            div = (rate_sel == 2'd0) ? 1 : (rate_sel == 2'd1) ? 2 : 4;
            m_pc++;
            if (m_pc >= div) begin
               m_pc = 0;
               judge(smp_jerk);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         checks++;
         if (single_tap !== m_s || double_tap !== m_d) begin
            errors++;
            $display("FAIL %s pulses got s=%0b d=%0b expected s=%0b d=%0b at cycle %0d",
                     req, single_tap, double_tap, m_s, m_d, cyc);
         end
         if (single_tap === 1'b1) seen_s++;
         if (double_tap === 1'b1) seen_d++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog expired in %s got running expected done", req);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic strobe(input int v);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_jerk  = 8'(v);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic burst(input int v, input int n);
      for (int i = 0; i < n; i++) strobe(v);
   endtask

   task automatic quiet(input int n);
      burst(0, n);
   endtask

   task automatic set_oper(input bit v);
      @(negedge clk);
      oper = v;
   endtask

   task automatic wreg(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_taps(input string r, input int es, input int ed);
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (seen_s != es || seen_d != ed) begin
         errors++;
         $display("FAIL %s tap counts got s=%0d d=%0d expected s=%0d d=%0d",
                  r, seen_s, seen_d, es, ed);
      end
      seen_s = 0;
      seen_d = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: outputs low after reset
      checks++;
      if (single_tap !== 1'b0 || double_tap !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset outputs got %0b%0b expected 00", single_tap, double_tap);
      end
      set_oper(1'b1);

      req = "R1";
      burst(100, 5); quiet(70);
      expect_taps("R1", 1, 0);

      req = "R3";
      burst(100, 1);  quiet(70);
      burst(100, 21); quiet(70);
      burst(100, 2);  quiet(70);
      burst(100, 20); quiet(70);
      expect_taps("R3", 2, 0);

      req = "R1";
      burst(26, 5);  quiet(70);
      burst(200, 5); quiet(70);
      burst(199, 5); quiet(70);
      burst(27, 5);  quiet(70);
      expect_taps("R1", 2, 0);

      req = "R5";
      burst(100, 5);  quiet(10); burst(100, 5);  quiet(70);
      burst(100, 18); quiet(3);  burst(100, 18); quiet(70);
      burst(100, 19); quiet(3);  burst(100, 18); quiet(70);
      expect_taps("R5", 0, 2);

      req = "R4";
      burst(100, 5); quiet(64); burst(100, 5); quiet(70);
      burst(100, 5); quiet(65); burst(100, 5); quiet(70);
      expect_taps("R4", 2, 1);

      req = "R6";
      burst(100, 5); quiet(3); burst(100, 1);  quiet(70);
      burst(100, 5); quiet(3); burst(100, 25); quiet(70);
      expect_taps("R6", 2, 0);

      req = "R9";
      burst(90, 4); quiet(2); burst(90, 3); quiet(70);
      expect_taps("R9", 0, 1);

      req = "R2";
      burst(100, 40); quiet(70);
      set_oper(1'b0); rate_sel = 2'd1; set_oper(1'b1);
      burst(100, 42); quiet(140);
      burst(100, 10); quiet(140);
      set_oper(1'b0); rate_sel = 2'd2; set_oper(1'b1);
      burst(100, 40); quiet(270);
      set_oper(1'b0); rate_sel = 2'd3; set_oper(1'b1);
      burst(100, 84); quiet(270);
      set_oper(1'b0); rate_sel = 2'd0; set_oper(1'b1);
      expect_taps("R2", 2, 0);

      req = "R7";
      wreg(1, 150);
      burst(100, 5); quiet(70);
      set_oper(1'b0); wreg(1, 150); set_oper(1'b1);
      burst(100, 5); quiet(70);
      burst(160, 5); quiet(70);
      set_oper(1'b0); wreg(0, 120); wreg(1, 26); set_oper(1'b1);
      burst(150, 5); quiet(70);
      burst(100, 5); quiet(70);
      set_oper(1'b0); wreg(0, 200); set_oper(1'b1);
      expect_taps("R7", 3, 0);

      req = "R8";
      burst(100, 5); quiet(10);
      set_oper(1'b0); quiet(2); set_oper(1'b1);
      quiet(70);
      burst(100, 3); set_oper(1'b0); set_oper(1'b1);
      burst(100, 1); quiet(70);
      expect_taps("R8", 0, 0);

      req = "R10";
      set_oper(1'b0); wreg(2, 'hF9); wreg(3, 8'd255); set_oper(1'b1);
      burst(100, 70); quiet(70);
      burst(100, 31); quiet(70);
      burst(100, 30); quiet(2); burst(100, 30); quiet(70);
      expect_taps("R10", 1, 1);

      req = "R11";
      set_oper(1'b0); wreg(2, 'hF9);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      set_oper(1'b1);
      burst(100, 25); quiet(70);
      burst(100, 5);  quiet(70);
      expect_taps("R11", 1, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule